// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block sits beside the receive and transmit FIFOs of a parallel bus controller and decides when the DMA controller should be asked to move data. In read direction it watches how many words wait in the receive FIFO. In write direction it watches how much room is left in the transmit FIFO. Each direction has its own request threshold and its own urgent (panic) threshold. The request and panic outputs are registered. They are gated by a DMA enable and by the transfer direction, so software can silence them while it reconfigures the controller.

A passthrough mode hands DMA pacing to the bus engine. The engine's per-transfer request then drives the request line directly, qualified by a per-direction permission bit. The block also reports plain FIFO status: receive data present, transmit space free, transmit FIFO empty, and the fill level of the FIFO that the current direction uses. The four 6-bit thresholds are loaded through a small write port.

Top module: `fifo_dreq_gen`

## Requirements
- R1: While `rstN` is low, `dreq` and `panic` are 0. Reset loads the threshold defaults: read request 1, write request 63, read panic 32, write panic 32.
- R2: With `dmaEnable`=1, `passthru`=0 and `isWrite`=0, `dreq` is 1 one clock after `rxLevel` is at or above the read request threshold, and 0 otherwise.
- R3: With `dmaEnable`=1, `passthru`=0 and `isWrite`=1, `dreq` is 1 one clock after the free transmit space (DEPTH − `txLevel`) is at or above the write request threshold. An empty transmit FIFO therefore raises a request with no transfer started.
- R4: In read direction, `panic` is 1 when a request is raised and `rxLevel` is at or above the read panic threshold.
- R5: In write direction, `panic` is 1 when a request is raised and `txLevel` is at or below the write panic threshold.
- R6: `panic` is never 1 while `dreq` is 0.
- R7: With `dmaEnable`=0 and `passthru`=0, `dreq` and `panic` are 0 one clock later, whatever the FIFO levels are.
- R8: With `passthru`=1, one clock later `dreq` equals `engineReq` AND (`wrPassEn` if `isWrite`=1, else `rdPassEn`). This ignores `dmaEnable` and the levels, and `panic` is 0.
- R9: The direction picks the thresholds and the level that count. In write direction the receive level has no effect on `dreq`. In read direction the transmit level has no effect on `dreq`.
- R10: A cycle with `cfgWe`=1 loads `cfgData` into the threshold chosen by `cfgSel`: 0 read request, 1 write request, 2 read panic, 3 write panic. The new value governs `dreq` and `panic` from the next clock on.
- R11: The status outputs follow the levels in the same cycle. `rxAvail` = (`rxLevel` ≠ 0). `txSpace` = (`txLevel` < DEPTH). `txEmpty` = (`txLevel` = 0). `fifoLevel` is `txLevel` when `isWrite`=1 and `rxLevel` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Threshold load strobe |
| cfgSel | input | 2 | Threshold select for the load |
| cfgData | input | 6 | Threshold value to load |
| dmaEnable | input | 1 | Enables level-driven requests |
| passthru | input | 1 | Request follows the bus engine |
| rdPassEn | input | 1 | Passthrough permitted in read direction |
| wrPassEn | input | 1 | Passthrough permitted in write direction |
| isWrite | input | 1 | Transfer direction, 1 = write |
| engineReq | input | 1 | Per-transfer request from the bus engine |
| rxLevel | input | 7 | Words in the receive FIFO |
| txLevel | input | 7 | Words in the transmit FIFO |
| dreq | output | 1 | DMA request |
| panic | output | 1 | Urgent DMA request |
| rxAvail | output | 1 | Receive FIFO holds data |
| txSpace | output | 1 | Transmit FIFO has room |
| txEmpty | output | 1 | Transmit FIFO is empty |
| fifoLevel | output | 7 | Fill level of the active-direction FIFO |

## Verification
The request and panic decisions land in the same registered cycle. Each level is therefore driven onto a point where both comparisons change together, or where only one of them does. Examples are a receive level of exactly 32 with the default thresholds, a transmit level that clears the write request threshold but not the panic one, and a panic threshold of zero with no request. In each case both outputs are compared against values worked out from the thresholds. A threshold load and a level change are also made back to back, and the output is judged in the cycle after the load takes effect.

// File: rtl/fdq_pkg.sv
package fdq_pkg;
  // load strobes from control to datapath, one per threshold
  typedef struct packed {
    logic ldWrPanic;
    logic ldRdPanic;
    logic ldWrReq;
    logic ldRdReq;
  } cfgStrobe_t;

  // level comparisons from datapath back to control
  typedef struct packed {
    logic rdReqHit;
    logic rdPanicHit;
    logic wrReqHit;
    logic wrPanicHit;
  } levelCmp_t;

  localparam int NUM_THR = 4;
endpackage

// File: rtl/fdq_datapath.sv
module fdq_datapath
  import fdq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TH_W = 6,
  parameter int LVL_W = 7,
  parameter logic [TH_W-1:0] RD_REQ_INIT = 1,
  parameter logic [TH_W-1:0] WR_REQ_INIT = 63,
  parameter logic [TH_W-1:0] RD_PANIC_INIT = 32,
  parameter logic [TH_W-1:0] WR_PANIC_INIT = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic [TH_W-1:0]  cfgData,
  input  logic             isWrite,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  output levelCmp_t        cmp,
  output logic             rxAvail,
  output logic             txSpace,
  output logic             txEmpty,
  output logic [LVL_W-1:0] fifoLevel
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  logic [NUM_THR-1:0] ldVec;
  logic [TH_W-1:0]    thr [NUM_THR];
  logic [TH_W-1:0]    thrInit [NUM_THR];
  logic [LVL_W-1:0]   txFree;

  assign ldVec = strobe;
  assign thrInit[0] = RD_REQ_INIT;
  assign thrInit[1] = WR_REQ_INIT;
  assign thrInit[2] = RD_PANIC_INIT;
  assign thrInit[3] = WR_PANIC_INIT;

  for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rstN)           thr[gi] <= thrInit[gi];
      else if (ldVec[gi])  thr[gi] <= cfgData;
    end
  end

  assign txFree = DEPTH_L - txLevel;

  always_comb begin
    cmp.rdReqHit   = rxLevel >= LVL_W'(thr[0]);
    cmp.wrReqHit   = txFree  >= LVL_W'(thr[1]);
    cmp.rdPanicHit = rxLevel >= LVL_W'(thr[2]);
    cmp.wrPanicHit = txLevel <= LVL_W'(thr[3]);
  end

  assign rxAvail   = rxLevel != '0;
  assign txSpace   = txLevel < DEPTH_L;
  assign txEmpty   = txLevel == '0;
  assign fifoLevel = isWrite ? txLevel : rxLevel;

  AST_EMPTY_HAS_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txSpace); // R11
  AST_RDREQ_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldRdReq |=> thr[0] == $past(cfgData)); // R10
  AST_WRPANIC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldWrPanic |=> thr[3] == $past(cfgData)); // R10
endmodule

// File: rtl/fdq_control.sv
module fdq_control
  import fdq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic       dmaEnable,
  input  logic       passthru,
  input  logic       rdPassEn,
  input  logic       wrPassEn,
  input  logic       isWrite,
  input  logic       engineReq,
  input  levelCmp_t  cmp,
  output cfgStrobe_t strobe,
  output logic       dreq,
  output logic       panic
);
  logic [NUM_THR-1:0] ldVec;
  logic reqHit, panicHit, passOk, dreqNext, panicNext;

  for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_dec
    assign ldVec[gi] = cfgWe && (cfgSel == 2'(gi));
  end
  assign strobe = ldVec;

  always_comb begin
    reqHit    = isWrite ? cmp.wrReqHit   : cmp.rdReqHit;
    panicHit  = isWrite ? cmp.wrPanicHit : cmp.rdPanicHit;
    passOk    = isWrite ? wrPassEn       : rdPassEn;
    dreqNext  = 1'b0;
    panicNext = 1'b0;
    if (passthru) begin
      dreqNext = engineReq && passOk;
    end else if (dmaEnable) begin
      dreqNext  = reqHit;
      panicNext = reqHit && panicHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dreq  <= 1'b0;
      panic <= 1'b0;
    end else begin
      dreq  <= dreqNext;
      panic <= panicNext;
    end
  end

  AST_PANIC_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    panic |-> dreq); // R6
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaEnable && !passthru) |=> (!dreq && !panic)); // R7
  AST_PASS_NO_PANIC: assert property (@(posedge clk) disable iff (!rstN)
    passthru |=> !panic); // R8
  AST_PASS_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (passthru && !engineReq) |=> !dreq); // R8
endmodule

// File: rtl/fifo_dreq_gen.sv
module fifo_dreq_gen
  import fdq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TH_W = 6,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [TH_W-1:0]  cfgData,
  input  logic             dmaEnable,
  input  logic             passthru,
  input  logic             rdPassEn,
  input  logic             wrPassEn,
  input  logic             isWrite,
  input  logic             engineReq,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  output logic             dreq,
  output logic             panic,
  output logic             rxAvail,
  output logic             txSpace,
  output logic             txEmpty,
  output logic [LVL_W-1:0] fifoLevel
);
  cfgStrobe_t strobe;
  levelCmp_t  cmp;

  fdq_datapath #(
    .DEPTH(DEPTH), .TH_W(TH_W), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgData(cfgData),
    .isWrite(isWrite), .rxLevel(rxLevel), .txLevel(txLevel), .cmp(cmp),
    .rxAvail(rxAvail), .txSpace(txSpace), .txEmpty(txEmpty),
    .fifoLevel(fifoLevel)
  );

  fdq_control u_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .dmaEnable(dmaEnable), .passthru(passthru), .rdPassEn(rdPassEn),
    .wrPassEn(wrPassEn), .isWrite(isWrite), .engineReq(engineReq),
    .cmp(cmp), .strobe(strobe), .dreq(dreq), .panic(panic)
  );
endmodule

// File: tb/test_fifo_dreq_gen.sv
`timescale 1ns/1ps
module test_fifo_dreq_gen;
  logic clk = 1'b0;
  logic rstN, cfgWe, dmaEnable, passthru, rdPassEn, wrPassEn, isWrite, engineReq;
  logic [1:0] cfgSel;
  logic [5:0] cfgData;
  logic [6:0] rxLevel, txLevel, fifoLevel;
  logic dreq, panic, rxAvail, txSpace, txEmpty;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fifo_dreq_gen i_fifo_dreq_gen (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .dmaEnable(dmaEnable), .passthru(passthru), .rdPassEn(rdPassEn),
    .wrPassEn(wrPassEn), .isWrite(isWrite), .engineReq(engineReq),
    .rxLevel(rxLevel), .txLevel(txLevel), .dreq(dreq), .panic(panic),
    .rxAvail(rxAvail), .txSpace(txSpace), .txEmpty(txEmpty), .fifoLevel(fifoLevel)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // apply levels, let one clock pass, sample at the next falling edge
  task automatic levels(logic wr, int rx, int tx);
    isWrite = wr; rxLevel = 7'(rx); txLevel = 7'(tx);
    @(negedge clk);
  endtask

  task automatic loadThr(int sel, int val);
    cfgSel = 2'(sel); cfgData = 6'(val); cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0; dmaEnable = 1'b1; isWrite = 1'b0; rxLevel = 7'd40; txLevel = 7'd0;
    repeat (3) @(negedge clk);
    check("R1 dreq in reset", dreq, 0);
    check("R1 panic in reset", panic, 0);
    rstN = 1'b1;
  endtask

  task automatic testReadDefaults();
    levels(0, 0, 10); check("R1 R2 rx=0 no req", dreq, 0);
    levels(0, 1, 10); check("R1 R2 rx=1 req", dreq, 1);
    check("R4 rx=1 no panic", panic, 0);
    levels(0, 31, 10); check("R4 rx=31 no panic", panic, 0);
    levels(0, 32, 10); check("R4 rx=32 panic", panic, 1);
    check("R2 rx=32 req", dreq, 1);
    levels(0, 64, 10); check("R4 rx=64 panic", panic, 1);
  endtask

  task automatic testWriteDefaults();
    levels(1, 0, 0); check("R3 empty tx raises req", dreq, 1);
    check("R5 empty tx panic", panic, 1);
    levels(1, 0, 1); check("R3 free=63 req", dreq, 1);
    levels(1, 0, 2); check("R3 free=62 no req", dreq, 0);
    check("R6 no panic without req", panic, 0);
  endtask

  task automatic testConfig();
    loadThr(0, 8);
    levels(0, 7, 0); check("R10 rx=7 below new thr", dreq, 0);
    levels(0, 8, 0); check("R10 rx=8 at new thr", dreq, 1);
    loadThr(1, 16); loadThr(3, 20);
    levels(1, 0, 40); check("R10 R3 tx=40 req", dreq, 1);
    check("R5 tx=40 no panic", panic, 0);
    levels(1, 0, 20); check("R5 tx=20 panic", panic, 1);
    levels(1, 0, 21); check("R5 tx=21 no panic", panic, 0);
    levels(1, 0, 49); check("R3 free=15 no req", dreq, 0);
    loadThr(2, 0);
    levels(0, 7, 0); check("R6 zero panic thr but no req", panic, 0);
    check("R6 dreq low", dreq, 0);
    levels(0, 8, 0); check("R4 zero panic thr with req", panic, 1);
  endtask

  task automatic testDirection();
    levels(1, 64, 64); check("R9 write ignores rx level", dreq, 0);
    levels(0, 0, 0); check("R9 read ignores empty tx", dreq, 0);
  endtask

  task automatic testDisable();
    levels(0, 40, 0); check("R7 setup req", dreq, 1);
    dmaEnable = 1'b0;
    @(negedge clk);
    check("R7 dreq drops in one clock", dreq, 0);
    check("R7 panic drops in one clock", panic, 0);
    levels(1, 0, 0); check("R7 empty tx while disabled", dreq, 0);
  endtask

  task automatic testPassthru();
    passthru = 1'b1; rdPassEn = 1'b1; wrPassEn = 1'b0; engineReq = 1'b1;
    levels(0, 0, 64); check("R8 read passthrough req", dreq, 1);
    check("R8 passthrough no panic", panic, 0);
    levels(1, 0, 0); check("R8 write not permitted", dreq, 0);
    wrPassEn = 1'b1;
    levels(1, 0, 64); check("R8 write permitted", dreq, 1);
    engineReq = 1'b0;
    levels(1, 0, 0); check("R8 engine idle", dreq, 0);
    passthru = 1'b0;
  endtask

  task automatic testStatus();
    isWrite = 1'b0; rxLevel = 7'd0; txLevel = 7'd64;
    #1;
    check("R11 rxAvail empty", rxAvail, 0);
    check("R11 txSpace full", txSpace, 0);
    check("R11 txEmpty full", txEmpty, 0);
    check("R11 level read dir", fifoLevel, 0);
    rxLevel = 7'd5; txLevel = 7'd0; isWrite = 1'b1;
    #1;
    check("R11 rxAvail data", rxAvail, 1);
    check("R11 txEmpty", txEmpty, 1);
    check("R11 txSpace", txSpace, 1);
    check("R11 level write dir", fifoLevel, 0);
    txLevel = 7'd33;
    #1;
    check("R11 level tracks tx", fifoLevel, 33);
    @(negedge clk);
  endtask

  initial begin
    cfgWe = 0; cfgSel = 0; cfgData = 0; passthru = 0; rdPassEn = 0;
    wrPassEn = 0; engineReq = 0;
    @(negedge clk);
    testReset();
    testReadDefaults();
    testWriteDefaults();
    testConfig();
    testDirection();
    testDisable();
    testPassthru();
    testStatus();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule